// File: doc/BRIEF.md
# Address-Match Breakpoint Unit

This unit provides hardware breakpoints for a small 8-bit processor with a 16-bit address bus. Software programs a 16-bit break address into two byte-wide registers. The unit compares that address with the processor address bus on every valid instruction fetch. When the addresses match and breakpoints are enabled, the unit raises a break request. Software can also raise a request directly by writing a one to the active bit of the control register.

A request does not take effect at once. It waits until the processor reports that the current instruction has finished. At that boundary, the unit tells the core to load a software-interrupt opcode into its instruction register. It also supplies the vector address, which depends on monitor mode. From the trigger until the break routine executes its return-from-interrupt, the watchdog is held off and the active status bit reads as one. Triggers that arrive while a break is already pending or in progress are dropped.

Top module: `brk_unit`

## Requirements
- R1: After reset, every register reads zero, and `bkpt_req`, `swi_inject` and `wdog_hold` are low.
- R2: Register offset 0 holds the high address byte and offset 1 holds the low byte. Offset 2 is the control register: bit 7 is the enable and reads back as written, and bit 6 is the read-only active status. Offset 3 reads zero.
- R3: When the enable is set, `fetch_vld` is high and `bus_addr` equals the break address, `bkpt_req` is high from the next cycle onward.
- R4: A fetch address that differs from the break address in either byte, even in a single bit, causes no request.
- R5: While the enable bit is clear, a matching fetch causes no request.
- R6: A matching address while `fetch_vld` is low causes no request.
- R7: Writing control bit 6 as one starts a request whatever the enable and the bus address are. Writing it as zero neither starts nor ends a break.
- R8: A pending request keeps `bkpt_req` high and `swi_inject` low until a cycle in which `insn_done` is high. In that cycle `swi_inject` is high. From the next cycle the break is active and `bkpt_req` is low.
- R9: `vec_addr` is 0xFFFC when `mon_mode` is low and 0xFEFC when it is high.
- R10: `wdog_hold` and status bit 6 are high from the cycle after a trigger until the cycle after an `rti` pulse seen while the break is active. An `rti` pulse while the request is still pending has no effect.
- R11: Address matches and software triggers during a pending or active break are ignored. After the return, no new request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| bus_addr | input | 16 | Processor address bus |
| fetch_vld | input | 1 | Address bus carries an instruction fetch |
| insn_done | input | 1 | Current instruction completes this cycle |
| rti | input | 1 | Return-from-interrupt executed |
| mon_mode | input | 1 | Monitor mode select |
| bkpt_req | output | 1 | Break request pending, sent to system logic |
| swi_inject | output | 1 | Load software-interrupt opcode this cycle |
| vec_addr | output | 16 | Break vector address (high byte location) |
| wdog_hold | output | 1 | Hold the watchdog disabled |

## Verification
On every cycle, the embedded assertions check the state sequencing. They confirm that a pending request survives until an instruction boundary, that an injection always leads to the active state, that an active break stays active until a return, and that a return ends it. They also check that a disabled unit with no software trigger never raises a request. The bench scenarios cover the things a property cannot see. These are byte-wise comparison over swept addresses, the fetch qualification, register readback, vector selection per mode, and the fact that triggers arriving during a break leave nothing pending afterwards.

// File: rtl/brk_pkg.sv
package brk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_ACT  = 2'd2
  } brk_st_e;

  localparam int CTRL_EN_BIT  = 7;
  localparam int CTRL_ACT_BIT = 6;
endpackage

// File: rtl/brk_cmp.sv
module brk_cmp #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic          eq
);
  always_comb eq = (a == b);
endmodule

// File: rtl/brk_regs.sv
module brk_regs #(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int RAW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           brk_busy,
  output logic [AW-1:0]  brk_addr,
  output logic           brk_en,
  output logic           sw_trig,
  output logic [DW-1:0]  reg_rdata
);
  import brk_pkg::*;

  localparam int NB = AW / DW;
  localparam logic [RAW-1:0] CTRL_OFS = RAW'(NB);

  logic [NB-1:0][DW-1:0] byte_q;
  logic [NB-1:0][DW-1:0] byte_d;
  logic                  en_q;
  logic                  en_d;
  logic                  ctrl_sel;

  always_comb ctrl_sel = reg_wr && (reg_addr == CTRL_OFS);

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic byte_we;
    always_comb begin
      byte_we   = reg_wr && (reg_addr == RAW'(k));
      byte_d[k] = byte_q[k];
      if (byte_we) byte_d[k] = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q[k] <= '0;
      else        byte_q[k] <= byte_d[k];
    end

    assign brk_addr[AW-1-k*DW -: DW] = byte_q[k];
  end

  always_comb begin
    en_d = en_q;
    if (ctrl_sel) en_d = reg_wdata[CTRL_EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  always_comb sw_trig = ctrl_sel && reg_wdata[CTRL_ACT_BIT];
  always_comb brk_en  = en_q;

  always_comb begin
    reg_rdata = '0;
    for (int k = 0; k < NB; k++) begin
      if (reg_addr == RAW'(k)) reg_rdata = byte_q[k];
    end
    if (reg_addr == CTRL_OFS) begin
      reg_rdata[CTRL_EN_BIT]  = en_q;
      reg_rdata[CTRL_ACT_BIT] = brk_busy;
    end
  end
endmodule

// File: rtl/brk_ctrl.sv
module brk_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic sw_trig,
  input  logic insn_done,
  input  logic rti,
  output logic st_pend,
  output logic st_act,
  output logic swi_inject
);
  import brk_pkg::*;

  brk_st_e st_q;
  brk_st_e st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (hit || sw_trig) st_d = ST_PEND;
      ST_PEND: if (insn_done)      st_d = ST_ACT;
      ST_ACT:  if (rti)            st_d = ST_IDLE;
      default:                     st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    st_pend    = (st_q == ST_PEND);
    st_act     = (st_q == ST_ACT);
    swi_inject = st_pend && insn_done;
  end

  // R8
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PEND && !insn_done) |=> (st_q == ST_PEND));

  // R8
  inject_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swi_inject |=> (st_q == ST_ACT));

  // R11
  act_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACT && !rti) |=> (st_q == ST_ACT));

  // R10
  rti_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ACT && rti) |=> (st_q == ST_IDLE));
endmodule

// File: rtl/brk_unit.sv
module brk_unit #(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter logic [15:0] VEC_NORM = 16'hFFFC,
  parameter logic [15:0] VEC_MON  = 16'hFEFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [15:0]   bus_addr,
  input  logic          fetch_vld,
  input  logic          insn_done,
  input  logic          rti,
  input  logic          mon_mode,
  output logic          bkpt_req,
  output logic          swi_inject,
  output logic [15:0]   vec_addr,
  output logic          wdog_hold
);
  localparam int NB  = AW / DW;
  localparam int RAW = 2;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic [AW-1:0] brk_addr;
  logic          brk_en;
  logic          sw_trig;
  logic [NB-1:0] byte_eq;
  logic          hit;
  logic          st_pend;
  logic          st_act;
  logic          busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  always_comb rst_int_n = rst_sync_q[1];

  brk_regs #(.AW(AW), .DW(DW), .RAW(RAW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .brk_busy  (busy),
    .brk_addr  (brk_addr),
    .brk_en    (brk_en),
    .sw_trig   (sw_trig),
    .reg_rdata (reg_rdata)
  );

  for (genvar k = 0; k < NB; k++) begin : g_cmp
    brk_cmp #(.DW(DW)) u_cmp (
      .a  (bus_addr[k*DW +: DW]),
      .b  (brk_addr[k*DW +: DW]),
      .eq (byte_eq[k])
    );
  end

  always_comb hit = brk_en && fetch_vld && (&byte_eq);

  brk_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .hit        (hit),
    .sw_trig    (sw_trig),
    .insn_done  (insn_done),
    .rti        (rti),
    .st_pend    (st_pend),
    .st_act     (st_act),
    .swi_inject (swi_inject)
  );

  always_comb begin
    busy      = st_pend || st_act;
    bkpt_req  = st_pend;
    wdog_hold = busy;
    vec_addr  = mon_mode ? VEC_MON : VEC_NORM;
  end

  // R5
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!brk_en && !sw_trig && !busy) |=> !bkpt_req);

  // R6
  fetch_gate_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!fetch_vld && !sw_trig && !busy) |=> !bkpt_req);
endmodule

// File: tb/brk_unit_tb.sv
module brk_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic [15:0] bus_addr = 16'd0;
  logic        fetch_vld = 1'b0;
  logic        insn_done = 1'b0;
  logic        rti = 1'b0;
  logic        mon_mode = 1'b0;
  logic        bkpt_req;
  logic        swi_inject;
  logic [15:0] vec_addr;
  logic        wdog_hold;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_unit u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_addr(bus_addr),
    .fetch_vld(fetch_vld), .insn_done(insn_done), .rti(rti),
    .mon_mode(mon_mode), .bkpt_req(bkpt_req), .swi_inject(swi_inject),
    .vec_addr(vec_addr), .wdog_hold(wdog_hold)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fetch(input logic [15:0] a, input logic v);
    bus_addr = a; fetch_vld = v;
    @(negedge clk);
    fetch_vld = 1'b0;
  endtask

  task automatic finish_break(input string req);
    insn_done = 1'b1;
    #1 chk(req, 16'(swi_inject), 16'd1);
    @(negedge clk);
    insn_done = 1'b0;
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
    chk(req, 16'(wdog_hold), 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    logic       exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), rv);
      chk("R1", 16'(rv), 16'd0);
    end
    chk("R1", 16'(bkpt_req), 16'd0);
    chk("R1", 16'(swi_inject), 16'd0);
    chk("R1", 16'(wdog_hold), 16'd0);

    // R2 register map
    wr(2'd0, 8'h12);
    wr(2'd1, 8'h34);
    wr(2'd2, 8'h80);
    rd(2'd0, rv); chk("R2", 16'(rv), 16'h12);
    rd(2'd1, rv); chk("R2", 16'(rv), 16'h34);
    rd(2'd2, rv); chk("R2", 16'(rv), 16'h80);
    rd(2'd3, rv); chk("R2", 16'(rv), 16'h00);

    // R3 R4 sweep of the low byte, then of the high byte
    for (int v = 0; v < 256; v++) begin
      exp = (v == 8'h34);
      fetch({8'h12, 8'(v)}, 1'b1);
      chk(exp ? "R3" : "R4", 16'(bkpt_req), 16'(exp));
      if (exp) finish_break("R3");
    end
    for (int v = 0; v < 256; v++) begin
      exp = (v == 8'h12);
      fetch({8'(v), 8'h34}, 1'b1);
      chk(exp ? "R3" : "R4", 16'(bkpt_req), 16'(exp));
      if (exp) finish_break("R3");
    end
    // R4 single-bit differences
    for (int b = 0; b < 16; b++) begin
      fetch(16'h1234 ^ (16'd1 << b), 1'b1);
      chk("R4", 16'(bkpt_req), 16'd0);
    end

    // R6 not a fetch
    fetch(16'h1234, 1'b0);
    chk("R6", 16'(bkpt_req), 16'd0);

    // R5 disabled
    wr(2'd2, 8'h00);
    fetch(16'h1234, 1'b1);
    chk("R5", 16'(bkpt_req), 16'd0);
    chk("R5", 16'(wdog_hold), 16'd0);

    // R7 software trigger with enable clear, address idle
    bus_addr = 16'h0000;
    wr(2'd2, 8'h40);
    chk("R7", 16'(bkpt_req), 16'd1);
    rd(2'd2, rv); chk("R7", 16'(rv), 16'h40);
    wr(2'd2, 8'h00);
    chk("R7", 16'(wdog_hold), 16'd1);

    // R10 rti while pending has no effect
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
    chk("R10", 16'(bkpt_req), 16'd1);
    chk("R10", 16'(wdog_hold), 16'd1);

    // R8 wait several cycles without a boundary
    repeat (5) @(negedge clk);
    chk("R8", 16'(bkpt_req), 16'd1);
    chk("R8", 16'(swi_inject), 16'd0);

    // R9 normal vector at injection
    mon_mode = 1'b0;
    insn_done = 1'b1;
    #1;
    chk("R8", 16'(swi_inject), 16'd1);
    chk("R9", vec_addr, 16'hFFFC);
    @(negedge clk);
    insn_done = 1'b0;
    chk("R8", 16'(bkpt_req), 16'd0);
    chk("R10", 16'(wdog_hold), 16'd1);
    rd(2'd2, rv); chk("R10", 16'(rv), 16'h40);

    // R11 triggers while active are ignored
    wr(2'd2, 8'hC0);
    fetch(16'h1234, 1'b1);
    chk("R11", 16'(bkpt_req), 16'd0);
    rti = 1'b1;
    @(negedge clk);
    rti = 1'b0;
    chk("R11", 16'(bkpt_req), 16'd0);
    chk("R10", 16'(wdog_hold), 16'd0);
    rd(2'd2, rv); chk("R11", 16'(rv), 16'h80);
    @(negedge clk);
    chk("R11", 16'(bkpt_req), 16'd0);

    // R9 monitor vector
    mon_mode = 1'b1;
    fetch(16'h1234, 1'b1);
    chk("R9", 16'(bkpt_req), 16'd1);
    #1 chk("R9", vec_addr, 16'hFEFC);
    finish_break("R9");
    mon_mode = 1'b0;
    #1 chk("R9", vec_addr, 16'hFFFC);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule